// File: doc/BRIEF.md
# Locked Command Mailbox with Interrupt Aggregation

This block is a small word-addressed register file between a host processor and a local controller. The host loads two argument words and then writes a command word. That write marks the mailbox busy and sends a one-cycle strobe with the command number to the controller. The controller later reports completion with an error flag and two result words. If the host asked for it, completion raises a command-finish interrupt. A third data word carries unsolicited traffic in both directions, with no flow control.

After power-up or a console NMI reset the mailbox is locked. While locked, only the key register listens. Every other register reads zero, ignores writes and raises no interrupt. Two specific key words written back to back unlock it. An all-ones key word locks it again and wipes the interrupt state. Four interrupt sources (button, command finish, USB-not-empty, auxiliary data) each have a pending flag with a write-1 clear. The USB and auxiliary sources also have enable and disable bits. Button and command finish are always enabled.

Top module: `cart_mailbox`

## Requirements
- R1: After hard reset (`rstN` low) or an `nmiReset` pulse the block is locked. While locked, `hostRdData` is 0 at every offset, `cartIrq` is 0, and host writes to any offset other than 0x10 change nothing.
- R2: Key writes go to offset 0x10. The pair 0x5F554E4C then 0x4F434B5F, written as two consecutive key writes, unlocks from the locked state. Any other key write between them (including 0x00000000, which clears the sequencer) breaks the pair, and a lone second word does nothing.
- R3: A key write of 0xFFFFFFFF locks the block when it is unlocked and has no effect when it is locked. Locking and `nmiReset` both clear all four pending flags and disable the USB and AUX sources.
- R4: When unlocked, offset 0x0C reads 0x53437632, and the write-only offsets 0x10 and 0x14 read 0.
- R5: DATA0 (0x04) and DATA1 (0x08) read back host writes. On `cmdDone` they load `resData0` and `resData1`, so DATA0 carries the error code of a failed command.
- R6: A host write to 0x00 sets busy, clears error, and latches the command number from bits [7:0] and the interrupt-request bit from bit [8]. In the next cycle `cmdStrobe` is 1 for exactly one cycle, with `cmdId` equal to the latched number.
- R7: On `cmdDone`, busy clears and error takes `cmdErr`. The command-finish flag is set only if the latched request bit is 1.
- R8: Offset 0x00 reads: [31] busy, [30] error, [29]/[28] button pending/mask, [27]/[26] command pending/mask, [25]/[24] USB pending/mask, [23]/[22] AUX pending/mask, [8] request, [7:0] command number, all other bits 0. The button and command masks always read 1.
- R9: Writing 1 to bits 31, 30, 29 or 28 of offset 0x14 clears the button, command, USB or AUX pending flag respectively. Bits written as 0 leave the flags alone.
- R10: At 0x14, bits 10/11 enable/disable the USB source and bits 8/9 enable/disable the AUX source. If both bits for one source are written as 1, disable wins.
- R11: Pending flags are set, only while unlocked, by a `btnEvent` pulse, a rising edge on `usbNotEmpty`, or `auxInValid`. A set in the same cycle as a clear wins.
- R12: `cartIrq` is 1 exactly when the block is unlocked and some source has both its pending flag and its mask at 1.
- R13: A host write to 0x18 gives a one-cycle `auxOutValid` in the next cycle, with the written word on `auxOutData`. `auxInValid` stores `auxInData`, which then reads back at 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| nmiReset | input | 1 | Console reset pulse: locks and clears interrupts |
| hostWrEn | input | 1 | Host write enable |
| hostAddr | input | 5 | Host byte offset |
| hostWrData | input | 32 | Host write word |
| hostRdData | output | 32 | Host read word (combinational on `hostAddr`) |
| cmdStrobe | output | 1 | One-cycle new-command pulse |
| cmdId | output | 8 | Latched command number |
| cmdArg0 | output | 32 | DATA0 contents |
| cmdArg1 | output | 32 | DATA1 contents |
| cmdDone | input | 1 | Controller completion pulse |
| cmdErr | input | 1 | Completion error flag |
| resData0 | input | 32 | Result or error code for DATA0 |
| resData1 | input | 32 | Result for DATA1 |
| auxInValid | input | 1 | Incoming auxiliary word valid |
| auxInData | input | 32 | Incoming auxiliary word |
| auxOutValid | output | 1 | Outgoing auxiliary word valid |
| auxOutData | output | 32 | Outgoing auxiliary word |
| btnEvent | input | 1 | Button event pulse |
| usbNotEmpty | input | 1 | USB receive-not-empty level |
| cartIrq | output | 1 | Interrupt to host, active high |
| unlocked | output | 1 | Lock state, 1 when registers are open |

## Verification
The bench targets the key sequencer's corner cases: an interrupted pair, a zero reset between the two words, a lone second word, and a lock word written while already locked. A faulty sequencer would unlock too easily or fail to lock. It sweeps command numbers and request/error combinations to catch a design that raises the finish interrupt without a request, keeps the stale error bit, or misplaces status fields. It also writes enable and disable together, and sets a flag in the same cycle as its clear, to expose wrong priority. Finally it fires events while locked and after an NMI, which catches a design that leaks interrupts or keeps stale pending state across a lock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OFS_W   = 5;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned NUM_SRC = 4;   // 0 aux, 1 usb, 2 cmd, 3 button
  localparam int unsigned PROG_SRC = 2;  // sources below this index have a writable mask

  localparam logic [OFS_W-1:0] OFS_SCR   = 5'h00;
  localparam logic [OFS_W-1:0] OFS_DATA0 = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DATA1 = 5'h08;
  localparam logic [OFS_W-1:0] OFS_IDENT = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_KEY   = 5'h10;
  localparam logic [OFS_W-1:0] OFS_IRQ   = 5'h14;
  localparam logic [OFS_W-1:0] OFS_AUX   = 5'h18;

  localparam logic [WORD_W-1:0] KEY_CLEAR  = 32'h0000_0000;
  localparam logic [WORD_W-1:0] KEY_FIRST  = 32'h5F55_4E4C;
  localparam logic [WORD_W-1:0] KEY_SECOND = 32'h4F43_4B5F;
  localparam logic [WORD_W-1:0] KEY_LOCK   = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] IDENT_VAL  = 32'h5343_7632;

  // status word field positions
  localparam int unsigned BIT_BUSY   = 31;
  localparam int unsigned BIT_ERR    = 30;
  localparam int unsigned BIT_SRC0   = 22;  // mask of source i at BIT_SRC0+2i, pending one above
  localparam int unsigned BIT_REQ    = 8;
  // irq word field positions
  localparam int unsigned BIT_CLR0   = 28;  // clear of source i at BIT_CLR0+i
  localparam int unsigned BIT_EN0    = 8;   // enable at BIT_EN0+2i, disable one above

  typedef struct packed {
    logic wrScr;
    logic wrData0;
    logic wrData1;
    logic wrIrq;
    logic wrAux;
    logic clearIrqs;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReset,
  input  logic              hostWrEn,
  input  logic [OFS_W-1:0]  hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output mbxStrobe_t        strb,
  output logic              unlocked
);
  logic unlockedQ;
  logic armedQ;
  logic keyWr;
  logic regWr;

  assign keyWr = hostWrEn && (hostAddr == OFS_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockedQ <= 1'b0;
      armedQ    <= 1'b0;
    end else if (nmiReset) begin
      unlockedQ <= 1'b0;
      armedQ    <= 1'b0;
    end else if (keyWr) begin
      if (hostWrData == KEY_FIRST) begin
        armedQ <= 1'b1;
      end else begin
        armedQ <= 1'b0;
        if (hostWrData == KEY_SECOND && armedQ && !unlockedQ) unlockedQ <= 1'b1;
        if (hostWrData == KEY_LOCK && unlockedQ) unlockedQ <= 1'b0;
      end
    end
  end

  assign regWr = hostWrEn && unlockedQ && !nmiReset;

  always_comb begin
    strb.wrScr     = regWr && (hostAddr == OFS_SCR);
    strb.wrData0   = regWr && (hostAddr == OFS_DATA0);
    strb.wrData1   = regWr && (hostAddr == OFS_DATA1);
    strb.wrIrq     = regWr && (hostAddr == OFS_IRQ);
    strb.wrAux     = regWr && (hostAddr == OFS_AUX);
    strb.clearIrqs = nmiReset || (keyWr && unlockedQ && hostWrData == KEY_LOCK);
  end

  assign unlocked = unlockedQ;
endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strb,
  input  logic              unlocked,
  input  logic [OFS_W-1:0]  hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              cmdStrobe,
  output logic [CMD_W-1:0]  cmdId,
  output logic [WORD_W-1:0] cmdArg0,
  output logic [WORD_W-1:0] cmdArg1,
  input  logic              cmdDone,
  input  logic              cmdErr,
  input  logic [WORD_W-1:0] resData0,
  input  logic [WORD_W-1:0] resData1,
  input  logic              auxInValid,
  input  logic [WORD_W-1:0] auxInData,
  output logic              auxOutValid,
  output logic [WORD_W-1:0] auxOutData,
  input  logic              btnEvent,
  input  logic              usbNotEmpty,
  output logic              cartIrq
);
  logic              busyQ, errQ, reqQ, strobeQ, auxOutValidQ, usbPrevQ;
  logic [CMD_W-1:0]  cmdIdQ;
  logic [WORD_W-1:0] data0Q, data1Q, auxInQ, auxOutQ;
  logic [NUM_SRC-1:0] pendQ, maskQ, setEvt;
  logic [WORD_W-1:0] scrWord;

  // command status and handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      errQ    <= 1'b0;
      reqQ    <= 1'b0;
      cmdIdQ  <= '0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= strb.wrScr;
      if (strb.wrScr) begin
        busyQ  <= 1'b1;
        errQ   <= 1'b0;
        reqQ   <= hostWrData[BIT_REQ];
        cmdIdQ <= hostWrData[CMD_W-1:0];
      end else if (cmdDone) begin
        busyQ <= 1'b0;
        errQ  <= cmdErr;
      end
    end
  end

  // argument / result words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      data0Q <= '0;
      data1Q <= '0;
    end else begin
      if (strb.wrData0)  data0Q <= hostWrData;
      else if (cmdDone)  data0Q <= resData0;
      if (strb.wrData1)  data1Q <= hostWrData;
      else if (cmdDone)  data1Q <= resData1;
    end
  end

  // auxiliary channel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxInQ       <= '0;
      auxOutQ      <= '0;
      auxOutValidQ <= 1'b0;
      usbPrevQ     <= 1'b0;
    end else begin
      usbPrevQ     <= usbNotEmpty;
      auxOutValidQ <= strb.wrAux;
      if (strb.wrAux) auxOutQ <= hostWrData;
      if (auxInValid) auxInQ  <= auxInData;
    end
  end

  assign setEvt = {btnEvent, cmdDone && reqQ, usbNotEmpty && !usbPrevQ, auxInValid}
                  & {NUM_SRC{unlocked}};

  // per-source pending flag and mask
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic pend;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    pend <= 1'b0;
      else if (strb.clearIrqs)                      pend <= 1'b0;
      else if (setEvt[i])                           pend <= 1'b1;
      else if (strb.wrIrq && hostWrData[BIT_CLR0+i]) pend <= 1'b0;
    end
    assign pendQ[i] = pend;

    if (i < PROG_SRC) begin : g_prog
      logic msk;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                         msk <= 1'b0;
        else if (strb.clearIrqs)                           msk <= 1'b0;
        else if (strb.wrIrq && hostWrData[BIT_EN0+2*i+1])  msk <= 1'b0;
        else if (strb.wrIrq && hostWrData[BIT_EN0+2*i])    msk <= 1'b1;
      end
      assign maskQ[i] = msk;
    end else begin : g_fixed
      assign maskQ[i] = 1'b1;
    end
  end

  assign cartIrq = unlocked && |(pendQ & maskQ);

  always_comb begin
    scrWord = '0;
    scrWord[BIT_BUSY] = busyQ;
    scrWord[BIT_ERR]  = errQ;
    scrWord[BIT_REQ]  = reqQ;
    scrWord[CMD_W-1:0] = cmdIdQ;
    for (int i = 0; i < NUM_SRC; i++) begin
      scrWord[BIT_SRC0+2*i]   = maskQ[i];
      scrWord[BIT_SRC0+2*i+1] = pendQ[i];
    end
  end

  always_comb begin
    hostRdData = '0;
    if (unlocked) begin
      case (hostAddr)
        OFS_SCR:   hostRdData = scrWord;
        OFS_DATA0: hostRdData = data0Q;
        OFS_DATA1: hostRdData = data1Q;
        OFS_IDENT: hostRdData = IDENT_VAL;
        OFS_AUX:   hostRdData = auxInQ;
        default:   hostRdData = '0;
      endcase
    end
  end

  assign cmdStrobe   = strobeQ;
  assign cmdId       = cmdIdQ;
  assign cmdArg0     = data0Q;
  assign cmdArg1     = data1Q;
  assign auxOutValid = auxOutValidQ;
  assign auxOutData  = auxOutQ;
endmodule

// File: rtl/cart_mailbox.sv
module cart_mailbox
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReset,
  input  logic              hostWrEn,
  input  logic [OFS_W-1:0]  hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              cmdStrobe,
  output logic [CMD_W-1:0]  cmdId,
  output logic [WORD_W-1:0] cmdArg0,
  output logic [WORD_W-1:0] cmdArg1,
  input  logic              cmdDone,
  input  logic              cmdErr,
  input  logic [WORD_W-1:0] resData0,
  input  logic [WORD_W-1:0] resData1,
  input  logic              auxInValid,
  input  logic [WORD_W-1:0] auxInData,
  output logic              auxOutValid,
  output logic [WORD_W-1:0] auxOutData,
  input  logic              btnEvent,
  input  logic              usbNotEmpty,
  output logic              cartIrq,
  output logic              unlocked
);
  mbxStrobe_t strb;

  mbx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .nmiReset(nmiReset),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .strb(strb), .unlocked(unlocked)
  );

  mbx_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .unlocked(unlocked),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .cmdStrobe(cmdStrobe), .cmdId(cmdId), .cmdArg0(cmdArg0), .cmdArg1(cmdArg1),
    .cmdDone(cmdDone), .cmdErr(cmdErr), .resData0(resData0), .resData1(resData1),
    .auxInValid(auxInValid), .auxInData(auxInData),
    .auxOutValid(auxOutValid), .auxOutData(auxOutData),
    .btnEvent(btnEvent), .usbNotEmpty(usbNotEmpty), .cartIrq(cartIrq)
  );
endmodule

// File: rtl/cart_mailbox_chk.sv
module cart_mailbox_chk
  import mbx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              nmiReset,
  input logic              unlocked,
  input logic              hostWrEn,
  input logic [OFS_W-1:0]  hostAddr,
  input logic [WORD_W-1:0] hostWrData,
  input logic [WORD_W-1:0] hostRdData,
  input logic              cmdStrobe,
  input logic              auxOutValid,
  input logic              cartIrq
);
  AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> (cartIrq == 1'b0 && hostRdData == '0)); // R1

  AST_NMI_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    nmiReset |=> !unlocked); // R1

  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(hostWrEn && hostAddr == OFS_KEY && hostWrData == KEY_SECOND)); // R2

  AST_LOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && !nmiReset && hostWrEn && hostAddr == OFS_KEY && hostWrData == KEY_LOCK) |=> !unlocked); // R3

  AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && !nmiReset && hostWrEn && hostAddr == OFS_SCR) |=> cmdStrobe); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && !(unlocked && hostWrEn && hostAddr == OFS_SCR)) |=> !cmdStrobe); // R6

  AST_AUX_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && !nmiReset && hostWrEn && hostAddr == OFS_AUX) |=> auxOutValid); // R13
endmodule

bind cart_mailbox cart_mailbox_chk uChk (
  .clk(clk), .rstN(rstN), .nmiReset(nmiReset), .unlocked(unlocked),
  .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
  .hostRdData(hostRdData), .cmdStrobe(cmdStrobe), .auxOutValid(auxOutValid),
  .cartIrq(cartIrq)
);

// File: tb/tb_cart_mailbox.sv
module tb_cart_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nmiReset = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        cmdStrobe;
  logic [7:0]  cmdId;
  logic [31:0] cmdArg0, cmdArg1;
  logic        cmdDone = 1'b0, cmdErr = 1'b0;
  logic [31:0] resData0 = '0, resData1 = '0;
  logic        auxInValid = 1'b0;
  logic [31:0] auxInData = '0;
  logic        auxOutValid;
  logic [31:0] auxOutData;
  logic        btnEvent = 1'b0, usbNotEmpty = 1'b0;
  logic        cartIrq, unlocked;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  localparam logic [31:0] K1 = 32'h5F55_4E4C;
  localparam logic [31:0] K2 = 32'h4F43_4B5F;
  localparam logic [31:0] FIXED_MASKS = 32'h1400_0000;

  always #5 clk = ~clk;

  cart_mailbox dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] msk, logic [31:0] exp, string tag);
    @(negedge clk);
    hostAddr = a; #1;
    check(tag, hostRdData & msk, exp & msk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(posedge clk); #1; sig = 1'b0;
  endtask

  task automatic unlockSeq();
    wr(5'h10, K1); wr(5'h10, K2);
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state, all offsets read zero, no interrupt
    for (int a = 0; a < 7; a++) rd(5'(a*4), '1, 32'h0, "R1 locked read");
    check("R1 irq at reset", {31'h0, cartIrq}, 32'h0);
    wr(5'h04, 32'h1234_5678);  // ignored while locked

    // R2: broken sequences keep the block locked
    wr(5'h10, K1); wr(5'h10, 32'h1234_5678); wr(5'h10, K2);
    check("R2 interrupted pair", {31'h0, unlocked}, 32'h0);
    wr(5'h10, K1); wr(5'h10, 32'h0); wr(5'h10, K2);
    check("R2 zero between words", {31'h0, unlocked}, 32'h0);
    wr(5'h10, K2);
    check("R2 lone second word", {31'h0, unlocked}, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);   // R3: lock while locked, no effect
    unlockSeq();
    check("R2 valid pair unlocks", {31'h0, unlocked}, 32'h1);

    rd(5'h0C, '1, 32'h5343_7632, "R4 identifier");
    rd(5'h10, '1, 32'h0, "R4 key reads zero");
    rd(5'h14, '1, 32'h0, "R4 irq reg reads zero");
    rd(5'h04, '1, 32'h0, "R1 locked write ignored");

    // R5: data register readback sweep
    for (int i = 1; i < 6; i++) begin
      wr(5'h04, 32'h1111_1111 * i);
      wr(5'h08, ~(32'h1111_1111 * i));
      rd(5'h04, '1, 32'h1111_1111 * i, "R5 data0");
      rd(5'h08, '1, ~(32'h1111_1111 * i), "R5 data1");
    end

    // R6 R7 R8 R5: command sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] id;
      logic req, err;
      id = 8'(8'h17 + i * 37);
      req = i[0]; err = i[1];
      wr(5'h00, {23'h0, req, id});
      check("R6 strobe", {31'h0, cmdStrobe}, 32'h1);
      check("R6 cmdId", {24'h0, cmdId}, {24'h0, id});
      @(posedge clk); #1;
      check("R6 strobe one cycle", {31'h0, cmdStrobe}, 32'h0);
      rd(5'h00, '1, 32'h8000_0000 | FIXED_MASKS | {23'h0, req, id}, "R8 busy status");
      @(negedge clk);
      cmdDone = 1'b1; cmdErr = err; resData0 = 32'hE000 + i; resData1 = 32'hD000 + i;
      @(posedge clk); #1; cmdDone = 1'b0;
      rd(5'h00, '1, FIXED_MASKS | ({31'h0, err} << 30) | ({31'h0, req} << 27) | {23'h0, req, id},
         "R7 done status");
      check("R12 cmd irq", {31'h0, cartIrq}, {31'h0, req});
      rd(5'h04, '1, 32'hE000 + i, "R5 result0");
      rd(5'h08, '1, 32'hD000 + i, "R5 result1");
      wr(5'h14, 32'h4000_0000);
      check("R9 cmd clear", {31'h0, cartIrq}, 32'h0);
    end

    // R11 R9: button pending, and set beating clear in the same cycle
    pulse(btnEvent);
    rd(5'h00, 32'h3000_0000, 32'h3000_0000, "R11 button pending");
    check("R12 button irq", {31'h0, cartIrq}, 32'h1);
    @(negedge clk);
    btnEvent = 1'b1; hostWrEn = 1'b1; hostAddr = 5'h14; hostWrData = 32'h8000_0000;
    @(posedge clk); #1; btnEvent = 1'b0; hostWrEn = 1'b0;
    rd(5'h00, 32'h2000_0000, 32'h2000_0000, "R11 set wins over clear");
    wr(5'h14, 32'h8000_0000);
    check("R9 button clear", {31'h0, cartIrq}, 32'h0);

    // R10: USB source masking
    @(negedge clk); usbNotEmpty = 1'b1;
    @(posedge clk); #1;
    rd(5'h00, 32'h0300_0000, 32'h0200_0000, "R11 usb edge pending");
    check("R12 masked usb", {31'h0, cartIrq}, 32'h0);
    wr(5'h14, 32'h0000_0400);
    check("R10 usb enable", {31'h0, cartIrq}, 32'h1);
    wr(5'h14, 32'h0000_0C00);
    check("R10 disable wins", {31'h0, cartIrq}, 32'h0);
    wr(5'h14, 32'h0000_0400);
    wr(5'h14, 32'h2000_0000);
    rd(5'h00, 32'h0300_0000, 32'h0100_0000, "R9 usb clear keeps mask");
    check("R11 level no retrigger", {31'h0, cartIrq}, 32'h0);
    @(negedge clk); usbNotEmpty = 1'b0;

    // R13: auxiliary channel
    @(negedge clk); auxInValid = 1'b1; auxInData = 32'hCAFE_0001;
    @(posedge clk); #1; auxInValid = 1'b0;
    rd(5'h18, '1, 32'hCAFE_0001, "R13 aux in stored");
    rd(5'h00, 32'h00C0_0000, 32'h0080_0000, "R11 aux pending");
    wr(5'h14, 32'h0000_0300);
    check("R10 aux disable wins", {31'h0, cartIrq}, 32'h0);
    wr(5'h14, 32'h0000_0100);
    check("R10 aux enable", {31'h0, cartIrq}, 32'h1);
    wr(5'h18, 32'h0BAD_F00D);
    check("R13 aux out valid", {31'h0, auxOutValid}, 32'h1);
    check("R13 aux out data", auxOutData, 32'h0BAD_F00D);
    @(posedge clk); #1;
    check("R13 aux out one cycle", {31'h0, auxOutValid}, 32'h0);

    // R3: lock clears interrupt state; events while locked ignored
    wr(5'h10, 32'hFFFF_FFFF);
    check("R3 locked", {31'h0, unlocked}, 32'h0);
    check("R1 irq off when locked", {31'h0, cartIrq}, 32'h0);
    rd(5'h18, '1, 32'h0, "R1 locked aux read");
    pulse(btnEvent);
    pulse(auxInValid);
    unlockSeq();
    rd(5'h00, 32'h3FC0_0000, FIXED_MASKS, "R3 lock cleared flags and masks");
    check("R12 no irq after relock", {31'h0, cartIrq}, 32'h0);

    // R1 R3: NMI reset
    pulse(btnEvent);
    check("R12 button before nmi", {31'h0, cartIrq}, 32'h1);
    pulse(nmiReset);
    check("R1 nmi locks", {31'h0, unlocked}, 32'h0);
    check("R1 nmi irq off", {31'h0, cartIrq}, 32'h0);
    rd(5'h0C, '1, 32'h0, "R1 nmi locked read");
    unlockSeq();
    rd(5'h00, 32'h3FC0_0000, FIXED_MASKS, "R3 nmi cleared flags");

    finished = 1;
    finish();
  end
endmodule